// File: doc/BRIEF.md
# Modem Line Control and Status with Loopback

This block holds the modem control byte and the modem status byte of a 16550-style serial controller. Software writes the control byte through a byte write strobe and reads the status byte through a read strobe. When the loop bit of the control byte is set, the four control outputs are fed back into the four status line inputs. When the loop bit is clear, those status lines read as zero, because no external modem pins are connected. The status byte also holds four sticky change bits. A change on CTS, DSR or DCD sets its own bit. The ring change bit is set only on a trailing edge of RI. Reading the status byte clears all four change bits. The level `chg_pend` reports that at least one change bit is set, and the interrupt logic uses it.

A small two-state machine tracks the mode. `MODE_DIRECT` is the state after reset. A control write with bit 4 set moves it to `MODE_LOOP` (transition `ENTER_LOOP`), and a control write with bit 4 clear moves it back (transition `LEAVE_LOOP`). Any other cycle keeps the current state (transition `HOLD`). The status lines are recomputed on the same clock edge that loads each control write. Status bit layout: DCTS=0, DDSR=1, TERI=2, DDCD=3, CTS=4, DSR=5, RI=6, DCD=7. Control bit layout: DTR=0, RTS=1, OUT1=2, OUT2=3, LOOP=4.

Top module: `mdm_loop_top`

## Requirements
- R1: After reset, `ctl_rdata`, `sts_rdata` and `chg_pend` are all zero and the mode is `MODE_DIRECT`.
- R2: A control write stores only bits 4:0 of `ctl_wdata`. From the next cycle, `ctl_rdata` shows those bits with bits 7:5 at zero.
- R3: When control bit 4 (LOOP) is set, the status bits follow the control bits from the cycle after the write: bit 4 (CTS) = bit 1 (RTS), bit 5 (DSR) = bit 0 (DTR), bit 6 (RI) = bit 2 (OUT1), bit 7 (DCD) = bit 3 (OUT2).
- R4: When control bit 4 is clear, status bits 7:4 are zero.
- R5: A control write that changes CTS, DSR or DCD sets status bit 0, 1 or 3 respectively.
- R6: Status bit 2 is set only when RI goes from 1 to 0. A 0-to-1 change of RI sets no change bit.
- R7: A set change bit stays set through later control writes until the status byte is read.
- R8: A read strobe `sts_re` returns the current value and clears bits 3:0 at that edge. A change produced by a control write in the same cycle as the read is kept. Bits 7:4 are not affected by a read.
- R9: A write to the status byte (`sts_we`) changes no bit of the status byte.
- R10: `chg_pend` is high exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| sts_we | input | 1 | Status byte write strobe (ignored) |
| sts_wdata | input | 8 | Status byte write data (ignored) |
| sts_re | input | 1 | Status byte read strobe; clears the change bits |
| sts_rdata | output | 8 | Status byte: line bits 7:4, change bits 3:0 |
| chg_pend | output | 1 | High while any change bit is set |

## Verification
A wrong mode state appears on `sts_rdata[7:4]` in the cycle after the control write that should have switched it. A wrong line snapshot shows up one write later, as a missing or spurious change bit. A change bit that is lost or wrongly cleared shows on `chg_pend` and `sts_rdata[3:0]` immediately, one cycle after the offending strobe. The bench therefore compares a behavioural model against every output on every clock. It also covers read-and-write collisions and trailing-versus-leading RI edges.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int BYTE_W    = 8;
    localparam int CTL_W     = 5;
    localparam int NIB_W     = 4;
    localparam int CTL_DTR   = 0;
    localparam int CTL_RTS   = 1;
    localparam int CTL_OUT1  = 2;
    localparam int CTL_OUT2  = 3;
    localparam int CTL_LOOP  = 4;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_LOOP   = 1'b1
    } mdm_mode_e;

    // line inputs as seen in status bits 7:4 (LSB = bit 4)
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    // change bits as seen in status bits 3:0
    typedef struct packed {
        logic ddcd;
        logic teri;
        logic ddsr;
        logic dcts;
    } mdm_delta_t;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int KEEP_W = CTL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          loop_on
);
    localparam int PAD_W = DW - KEEP_W;

    mdm_mode_e          mode_q, mode_d;
    logic [KEEP_W-2:0]  outs_q;

    // next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_DIRECT: if (wr_en && wr_data[CTL_LOOP])  mode_d = MODE_LOOP;   // ENTER_LOOP
            MODE_LOOP:   if (wr_en && !wr_data[CTL_LOOP]) mode_d = MODE_DIRECT; // LEAVE_LOOP
        endcase
    end

    // state register and control outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_DIRECT;
            outs_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (wr_en) outs_q <= wr_data[KEEP_W-2:0];
        end
    end

    // output process
    always_comb begin
        loop_on = (mode_q == MODE_LOOP);
        rd_data = {{PAD_W{1'b0}}, loop_on, outs_q};
    end
endmodule

// File: rtl/mdm_line_map.sv
module mdm_line_map
    import mdm_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic [DW-1:0] ctl,
    output mdm_lines_t    lines
);
    always_comb begin
        lines = '0;
        if (ctl[CTL_LOOP]) begin
            lines.cts = ctl[CTL_RTS];
            lines.dsr = ctl[CTL_DTR];
            lines.ri  = ctl[CTL_OUT1];
            lines.dcd = ctl[CTL_OUT2];
        end
    end
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  mdm_lines_t new_lines,
    input  logic       rd_clr,
    output mdm_lines_t lines,
    output mdm_delta_t delta,
    output logic       any_delta
);
    mdm_lines_t lines_q;
    mdm_delta_t delta_q, delta_d, fresh;

    always_comb begin
        fresh = '0;
        if (upd) begin
            fresh.dcts = new_lines.cts ^ lines_q.cts;
            fresh.ddsr = new_lines.dsr ^ lines_q.dsr;
            fresh.ddcd = new_lines.dcd ^ lines_q.dcd;
            fresh.teri = lines_q.ri & ~new_lines.ri;
        end
        delta_d = (rd_clr ? mdm_delta_t'('0) : delta_q) | fresh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
            delta_q <= '0;
        end else begin
            if (upd) lines_q <= new_lines;
            delta_q <= delta_d;
        end
    end

    assign lines     = lines_q;
    assign delta     = delta_q;
    assign any_delta = |delta_q;
endmodule

// File: rtl/mdm_loop_top.sv
module mdm_loop_top
    import mdm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic        sts_we,
    input  logic [7:0]  sts_wdata,
    input  logic        sts_re,
    output logic [7:0]  sts_rdata,
    output logic        chg_pend
);
    mdm_lines_t next_lines, cur_lines;
    mdm_delta_t cur_delta;
    logic       loop_on;
    logic       sts_wr_unused;

    // the status byte has no writable bits
    assign sts_wr_unused = sts_we ^ (^sts_wdata);

    mdm_ctl_reg #(.DW(BYTE_W), .KEEP_W(CTL_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_we),
        .wr_data (ctl_wdata),
        .rd_data (ctl_rdata),
        .loop_on (loop_on)
    );

    mdm_line_map #(.DW(BYTE_W)) u_map (
        .ctl   (ctl_wdata),
        .lines (next_lines)
    );

    mdm_delta_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (ctl_we),
        .new_lines (next_lines),
        .rd_clr    (sts_re),
        .lines     (cur_lines),
        .delta     (cur_delta),
        .any_delta (chg_pend)
    );

    assign sts_rdata = {cur_lines, cur_delta};
endmodule

// File: rtl/mdm_loop_chk.sv
module mdm_loop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic       sts_we,
    input logic       sts_re,
    input logic [7:0] sts_rdata,
    input logic       chg_pend
);
    assert_ctl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_rdata == {3'b000, $past(ctl_wdata[4:0])});

    assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |-> sts_rdata[7:4] == {ctl_rdata[3], ctl_rdata[2], ctl_rdata[0], ctl_rdata[1]});

    assert_direct_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[4] |-> sts_rdata[7:4] == 4'h0);

    assert_ri_trailing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !sts_re && !sts_rdata[2]) |=> (sts_rdata[2] == ($past(sts_rdata[6]) && !sts_rdata[6])));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_re |=> (sts_rdata[3:0] & $past(sts_rdata[3:0])) == $past(sts_rdata[3:0]));

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_re && !ctl_we) |=> sts_rdata[3:0] == 4'h0);

    assert_sts_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && !ctl_we && !sts_re) |=> sts_rdata == $past(sts_rdata));

    assert_pend_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pend == (sts_rdata[3:0] != 4'h0));
endmodule

bind mdm_loop_top mdm_loop_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .sts_we    (sts_we),
    .sts_re    (sts_re),
    .sts_rdata (sts_rdata),
    .chg_pend  (chg_pend)
);

// File: tb/mdm_loop_top_test.sv
`timescale 1ns/1ps
module mdm_loop_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       sts_we = 1'b0;
    logic [7:0] sts_wdata = 8'h00;
    logic       sts_re = 1'b0;
    logic [7:0] sts_rdata;
    logic       chg_pend;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_ctl = 0;
    int m_lines = 0;
    int m_delta = 0;

    always #2.5 clk = ~clk;

    mdm_loop_top uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .sts_re(sts_re), .sts_rdata(sts_rdata), .chg_pend(chg_pend)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model step, applied at each rising edge
    task automatic model_edge(input bit we, input int wd, input bit re);
        int nctl, nl, d;
        if (we) begin
            nctl = wd % 32;
            nl = 0;
            if (nctl >= 16) begin
                if ((nctl / 2) % 2 == 1) nl += 1;  // RTS -> CTS
                if (nctl % 2 == 1)       nl += 2;  // DTR -> DSR
                if ((nctl / 4) % 2 == 1) nl += 4;  // OUT1 -> RI
                if ((nctl / 8) % 2 == 1) nl += 8;  // OUT2 -> DCD
            end
            d = re ? 0 : m_delta;
            if ((nl % 2) != (m_lines % 2))             d |= 1;
            if ((nl / 2) % 2 != (m_lines / 2) % 2)     d |= 2;
            if ((nl / 8) % 2 != (m_lines / 8) % 2)     d |= 8;
            if ((m_lines / 4) % 2 == 1 && (nl / 4) % 2 == 0) d |= 4;
            m_ctl = nctl;
            m_lines = nl;
            m_delta = d;
        end else if (re) begin
            m_delta = 0;
        end
    endtask

    task automatic compare_model();
        check("model ctl R2", ctl_rdata, m_ctl);
        check("model sts R5", sts_rdata, m_lines * 16 + m_delta);
        check("model pend R10", chg_pend, (m_delta != 0) ? 1 : 0);
    endtask

    task automatic step(input bit we, input int wd, input bit swe, input int swd, input bit re);
        @(negedge clk);
        ctl_we = we; ctl_wdata = wd[7:0];
        sts_we = swe; sts_wdata = swd[7:0];
        sts_re = re;
        @(posedge clk);
        model_edge(we, wd, re);
        #1;
        compare_model();
        @(negedge clk);
        ctl_we = 0; sts_we = 0; sts_re = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 ctl reset", ctl_rdata, 8'h00);
        check("R1 sts reset", sts_rdata, 8'h00);
        check("R1 pend reset", chg_pend, 0);

        step(1, 8'hFF, 0, 0, 0);
        check("R2 masked ctl", ctl_rdata, 8'h1F);
        check("R3 loop lines", sts_rdata[7:4], 4'hF);
        check("R5 CTS/DSR/DCD deltas", sts_rdata[3:0], 4'hB);
        check("R6 no TERI on rise", sts_rdata[2], 0);
        check("R10 pend high", chg_pend, 1);

        step(0, 0, 0, 0, 1);
        check("R8 read clears", sts_rdata, 8'hF0);
        check("R10 pend low", chg_pend, 0);

        step(1, 8'h10, 0, 0, 0);
        check("R6 TERI on fall", sts_rdata, 8'h0F);

        step(0, 0, 1, 8'hFF, 0);
        check("R9 sts write ignored", sts_rdata, 8'h0F);
        step(0, 0, 1, 8'h00, 0);
        check("R9 sts write zero ignored", sts_rdata, 8'h0F);

        step(1, 8'h12, 0, 0, 0);
        check("R7 sticky", sts_rdata, 8'h1F);

        step(1, 8'h13, 0, 0, 1);
        check("R8 read with write", sts_rdata, 8'h32);

        step(1, 8'h03, 0, 0, 0);
        check("R4 direct zero", sts_rdata, 8'h03);
        check("R2 ctl direct", ctl_rdata, 8'h03);

        step(0, 0, 0, 0, 1);
        step(1, 8'h0F, 0, 0, 0);
        check("R4 outs ignored direct", sts_rdata, 8'h00);

        step(1, 8'h14, 0, 0, 0);
        check("R6 RI rise only", sts_rdata, 8'h40);
        check("R10 no pend", chg_pend, 0);

        step(1, 8'h1C, 0, 0, 0);
        check("R3 OUT2 to DCD", sts_rdata, 8'hC8);

        for (int i = 0; i < 40; i++)
            step((i % 3) != 0, (i * 37 + 5) % 256, (i % 5) == 0, i, (i % 4) == 1);

        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 re-reset sts", sts_rdata, 8'h00);
        check("R1 re-reset ctl", ctl_rdata, 8'h00);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule